// File: doc/BRIEF.md
# Flash page program-verify sequencer

This block writes one 128-byte page into a behavioural flash array and then proves the write with a program/verify loop. A host fills a page buffer byte by byte, sets a page start address and a pulse length, and pulses `start`. Any offset the host never loaded holds 0xFF. The block first checks the request. If it is accepted, the block streams the page into the array latch, holds the program-enable pulse for the requested number of cycles, and then reads the page back. Each read is preceded by a dummy write.

The array cells can only move from 1 to 0. The block therefore rebuilds the next pulse's data from the readback, so that only bits still reading 1 where 0 is wanted are driven again. The loop ends when the whole page matches or the pulse budget is used up. A watchdog cuts off any pulse that runs past its window. The array model has a small cell-weakness control, so that slow or dead bits can be staged.

Top module: `fpv_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `err` and `wdt_fail` are 0, and every array byte reads 0xFF on `rd_data`.
- R2: If the low 8 bits of `start_addr` are anything other than 0x00 or 0x80, the start is refused. In the cycle after the start, `done` and `err` are 1 and `busy` is never raised. The array is unchanged.
- R3: A start is also refused in the same way when any byte of the target page is not 0xFF, or when `pulse_len` is 0.
- R4: Byte offset `ld_idx` of the page takes `ld_data` when `ld_en` is high and the block is idle. Offsets not loaded are programmed as 0xFF. After every `done`, the buffer returns to all 0xFF.
- R5: Before each pulse, all 128 page bytes are written into the array latch in ascending offset order.
- R6: Program-enable stays high for exactly `pulse_len` cycles, captured at the accepted start.
- R7: A pulse that reaches WDT_CYC cycles without ending is cleared. `done` and `wdt_fail` are then raised with `pass` 0. A `pulse_len` equal to WDT_CYC completes normally, because the normal end takes priority in the same cycle.
- R8: Every verify read of a 4-byte group comes in the cycle right after a dummy write of 0xFF to the same address, whose low two bits are 00. One verify pass takes 64 cycles.
- R9: Each pass re-drives only the bits that should be 0 but read 1 (next byte = target OR NOT readback). An accepted sequence keeps `busy` high for k*(192+`pulse_len`) cycles, where k is the number of pulses used.
- R10: If the page still mismatches after MAX_PULSES pulses, `done` is raised with `pass`, `err` and `wdt_fail` all 0. Bits that did program stay programmed.
- R11: The array only clears bits: each programmed byte becomes the stored value AND the latched value.
- R12: A `start` while `busy` is high is ignored. `busy` stays high from the cycle after an accepted start until `done`.
- R13: `done` lasts one cycle. At most one of `pass`, `err` and `wdt_fail` is high, and they hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Page buffer byte load strobe |
| ld_idx | input | 7 | Byte offset within the page |
| ld_data | input | 8 | Byte to load |
| start | input | 1 | Start a page program request |
| start_addr | input | ADDR_W | Page start address |
| pulse_len | input | 16 | Program pulse length in cycles |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| tst_addr | input | ADDR_W | Cell model: address of the weak byte |
| tst_mask | input | 8 | Cell model: weak bits of that byte |
| tst_need | input | 4 | Cell model: pulse number on which weak bits first program (0 = none weak) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Page verified |
| err | output | 1 | Request refused |
| wdt_fail | output | 1 | Pulse aborted by watchdog |

## Verification
The two functions that can land in one cycle are the normal end of a program pulse and the watchdog overflow. This happens when `pulse_len` equals the watchdog window. The bench runs that length and the length one cycle longer. It judges each run by the result flags and by the exact count of busy cycles: 128+W+64 when the pulse ends normally, and 128+W when the watchdog cuts it. A second collision is a `start` raised in the middle of a running sequence. The bench judges this by an unchanged busy count and result.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
    localparam int PAGE_BYTES = 128;
    localparam int IDX_W      = $clog2(PAGE_BYTES);
    localparam int VW_BYTES   = 4;
    localparam int VW_W       = $clog2(VW_BYTES);
    localparam int GRPS       = PAGE_BYTES / VW_BYTES;
    localparam int GRP_W      = $clog2(GRPS);
    localparam logic [7:0] ERASED = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_XFER, S_PULSE, S_VDW, S_VRD, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic pass;
        logic err;
        logic wdt;
    } result_t;

    typedef logic [VW_BYTES*8-1:0] vword_t;

    // R9: drive again only bits wanted 0 that still read 1
    function automatic logic [7:0] reprog_byte(input logic [7:0] tgt, input logic [7:0] rb);
        return tgt | ~rb;
    endfunction

    function automatic logic page_aligned(input logic [IDX_W-1:0] low);
        return low == '0;
    endfunction
endpackage

// File: rtl/fpv_array.sv
module fpv_array import fpv_pkg::*; #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              pe,
    input  logic              dw,
    input  logic              rd,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output vword_t            rdata,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              blank,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic [7:0]        tst_mask,
    input  logic [3:0]        tst_need
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PG_W  = ADDR_W - IDX_W;

    logic [7:0]        mem   [DEPTH];
    logic [7:0]        latch [PAGE_BYTES];
    logic [PG_W-1:0]   lat_pg;
    logic              pe_q;
    logic              armed;
    logic [ADDR_W-1:0] armed_addr;
    logic [3:0]        npulse;
    logic              commit;

    assign commit = pe_q & ~pe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
            for (int i = 0; i < PAGE_BYTES; i++) latch[i] <= ERASED;
            lat_pg     <= '0;
            pe_q       <= 1'b0;
            armed      <= 1'b0;
            armed_addr <= '0;
            npulse     <= '0;
        end else begin
            pe_q       <= pe;
            armed      <= dw && (wdata == ERASED) && (addr[1:0] == 2'b00);
            armed_addr <= addr;
            if (we) begin
                latch[addr[IDX_W-1:0]] <= wdata;
                lat_pg                 <= addr[ADDR_W-1:IDX_W];
            end
            if (clr) begin
                npulse <= '0;
            end else if (commit && npulse != 4'hF) begin
                npulse <= npulse + 4'd1;
            end
            if (commit) begin
                // R11: cells only move from 1 to 0
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    mem[{lat_pg, IDX_W'(i)}] <= mem[{lat_pg, IDX_W'(i)}] &
                        (latch[i] | ((({lat_pg, IDX_W'(i)} == tst_addr) &&
                                      ({1'b0, npulse} + 5'd1 < {1'b0, tst_need})) ? tst_mask : 8'h00));
                end
            end
        end
    end

    always_comb begin
        blank = 1'b1;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (mem[{chk_addr[ADDR_W-1:IDX_W], IDX_W'(i)}] != ERASED) blank = 1'b0;
        end
    end

    // R8: verify data is only returned right after a dummy write to the same address
    always_comb begin
        for (int j = 0; j < VW_BYTES; j++) begin
            rdata[8*j +: 8] = (rd && armed && armed_addr == addr) ? mem[addr | ADDR_W'(j)] : ERASED;
        end
    end

    assign peek_data = mem[peek_addr];
endmodule

// File: rtl/fpv_pagebuf.sv
module fpv_pagebuf import fpv_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [7:0]       ld_data,
    input  logic             clear,
    input  logic             snap,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    input  logic             upd_en,
    input  logic [GRP_W-1:0] upd_grp,
    input  vword_t           rb,
    output logic             grp_miss
);
    logic [7:0] tgt [PAGE_BYTES];
    logic [7:0] rep [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            // R4: all-ones padding for every unloaded offset
            for (int i = 0; i < PAGE_BYTES; i++) begin
                tgt[i] <= ERASED;
                rep[i] <= ERASED;
            end
        end else begin
            if (ld_en) tgt[ld_idx] <= ld_data;
            if (snap) begin
                for (int i = 0; i < PAGE_BYTES; i++) rep[i] <= tgt[i];
            end
            if (upd_en) begin
                for (int j = 0; j < VW_BYTES; j++) begin
                    rep[{upd_grp, VW_W'(j)}] <= reprog_byte(tgt[{upd_grp, VW_W'(j)}], rb[8*j +: 8]);
                end
            end
        end
    end

    always_comb begin
        grp_miss = 1'b0;
        for (int j = 0; j < VW_BYTES; j++) begin
            if (tgt[{upd_grp, VW_W'(j)}] != rb[8*j +: 8]) grp_miss = 1'b1;
        end
    end

    assign rd_byte = rep[rd_idx];
endmodule

// File: rtl/fpv_ctrl.sv
module fpv_ctrl import fpv_pkg::*; #(
    parameter int ADDR_W     = 9,
    parameter int WDT_CYC    = 1320000,
    parameter int MAX_PULSES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [15:0]       pulse_len,
    input  logic              blank,
    input  logic              grp_miss,
    input  logic [7:0]        rep_byte,
    output logic              busy,
    output logic              done,
    output result_t           res,
    output logic              snap,
    output logic              clear,
    output logic [IDX_W-1:0]  xfer_idx,
    output logic              upd_en,
    output logic [GRP_W-1:0]  upd_grp,
    output logic              arr_we,
    output logic              arr_pe,
    output logic              arr_dw,
    output logic              arr_rd,
    output logic              arr_clr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    localparam int CNT_W = $clog2(WDT_CYC + 1);
    localparam int PC_W  = (CNT_W > 16) ? CNT_W : 16;
    localparam int NP_W  = $clog2(MAX_PULSES + 1);

    seq_state_e        st;
    logic [ADDR_W-1:0] base;
    logic [15:0]       plen;
    logic [IDX_W-1:0]  idx;
    logic [GRP_W-1:0]  grp;
    logic [PC_W-1:0]   pcnt;
    logic [NP_W-1:0]   np;
    logic              miss;
    logic              accept;
    logic              pulse_end;
    logic              wdt_hit;

    // R2, R3: alignment, blank page and nonzero pulse length
    assign accept    = page_aligned(start_addr[IDX_W-1:0]) && blank && (pulse_len != 16'd0);
    // R7: normal end is tested before the watchdog
    assign pulse_end = (pcnt == PC_W'(plen) - PC_W'(1));
    assign wdt_hit   = (pcnt == PC_W'(WDT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            base <= '0;
            plen <= '0;
            idx  <= '0;
            grp  <= '0;
            pcnt <= '0;
            np   <= '0;
            miss <= 1'b0;
            res  <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        res <= '{pass: 1'b0, err: !accept, wdt: 1'b0};
                        if (accept) begin
                            base <= start_addr;
                            plen <= pulse_len;
                            idx  <= '0;
                            np   <= '0;
                            st   <= S_XFER;
                        end else begin
                            st <= S_DONE;
                        end
                    end
                end
                S_XFER: begin
                    idx <= idx + IDX_W'(1);
                    if (idx == IDX_W'(PAGE_BYTES - 1)) begin
                        pcnt <= '0;
                        st   <= S_PULSE;
                    end
                end
                S_PULSE: begin
                    if (pulse_end) begin
                        np   <= np + NP_W'(1);
                        grp  <= '0;
                        miss <= 1'b0;
                        st   <= S_VDW;
                    end else if (wdt_hit) begin
                        res.wdt <= 1'b1;
                        st      <= S_DONE;
                    end else begin
                        pcnt <= pcnt + PC_W'(1);
                    end
                end
                S_VDW: st <= S_VRD;
                S_VRD: begin
                    if (grp == GRP_W'(GRPS - 1)) begin
                        if (!(miss || grp_miss)) begin
                            res.pass <= 1'b1;
                            st       <= S_DONE;
                        end else if (np == NP_W'(MAX_PULSES)) begin
                            st <= S_DONE;
                        end else begin
                            idx <= '0;
                            st  <= S_XFER;
                        end
                    end else begin
                        grp  <= grp + GRP_W'(1);
                        miss <= miss || grp_miss;
                        st   <= S_VDW;
                    end
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st == S_XFER) || (st == S_PULSE) || (st == S_VDW) || (st == S_VRD);
        done      = (st == S_DONE);
        clear     = done;
        snap      = (st == S_IDLE) && start && accept;
        arr_clr   = snap;
        xfer_idx  = idx;
        upd_en    = (st == S_VRD);
        upd_grp   = grp;
        arr_we    = (st == S_XFER);
        arr_pe    = (st == S_PULSE);
        arr_dw    = (st == S_VDW);
        arr_rd    = (st == S_VRD);
        arr_wdata = (st == S_XFER) ? rep_byte : ERASED;
        unique case (st)
            S_XFER:       arr_addr = base | ADDR_W'(idx);
            S_VDW, S_VRD: arr_addr = base | ADDR_W'({grp, {VW_W{1'b0}}});
            default:      arr_addr = base;
        endcase
    end
endmodule

// File: rtl/fpv_seq.sv
module fpv_seq import fpv_pkg::*; #(
    parameter int ADDR_W     = 9,
    parameter int WDT_CYC    = 1320000,
    parameter int MAX_PULSES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [7:0]        ld_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [15:0]       pulse_len,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic [7:0]        tst_mask,
    input  logic [3:0]        tst_need,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              err,
    output logic              wdt_fail
);
    result_t           res;
    logic              snap, clear, upd_en, grp_miss, blank;
    logic [IDX_W-1:0]  xfer_idx;
    logic [GRP_W-1:0]  upd_grp;
    logic [7:0]        rep_byte;
    logic              arr_we, arr_pe, arr_dw, arr_rd, arr_clr;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;
    vword_t            arr_rdata;
    logic              ld_ok;

    assign ld_ok    = ld_en && !busy && !done;
    assign pass     = res.pass;
    assign err      = res.err;
    assign wdt_fail = res.wdt;

    fpv_ctrl #(.ADDR_W(ADDR_W), .WDT_CYC(WDT_CYC), .MAX_PULSES(MAX_PULSES)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .pulse_len(pulse_len),
        .blank(blank), .grp_miss(grp_miss), .rep_byte(rep_byte),
        .busy(busy), .done(done), .res(res), .snap(snap), .clear(clear),
        .xfer_idx(xfer_idx), .upd_en(upd_en), .upd_grp(upd_grp),
        .arr_we(arr_we), .arr_pe(arr_pe), .arr_dw(arr_dw), .arr_rd(arr_rd), .arr_clr(arr_clr),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    fpv_pagebuf u_buf (
        .clk(clk), .rst(rst), .ld_en(ld_ok), .ld_idx(ld_idx), .ld_data(ld_data),
        .clear(clear), .snap(snap), .rd_idx(xfer_idx), .rd_byte(rep_byte),
        .upd_en(upd_en), .upd_grp(upd_grp), .rb(arr_rdata), .grp_miss(grp_miss)
    );

    fpv_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst(rst), .we(arr_we), .pe(arr_pe), .dw(arr_dw), .rd(arr_rd), .clr(arr_clr),
        .addr(arr_addr), .wdata(arr_wdata), .rdata(arr_rdata),
        .chk_addr(start_addr), .blank(blank),
        .peek_addr(rd_addr), .peek_data(rd_data),
        .tst_addr(tst_addr), .tst_mask(tst_mask), .tst_need(tst_need)
    );
endmodule

// File: rtl/fpv_chk.sv
module fpv_chk import fpv_pkg::*; #(
    parameter int ADDR_W  = 9,
    parameter int WDT_CYC = 1320000
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [15:0]       pulse_len,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              err,
    input logic              wdt_fail,
    input logic              arr_we,
    input logic              arr_pe,
    input logic              arr_dw,
    input logic              arr_rd,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        arr_wdata
);
    logic [31:0] pe_run;
    logic [31:0] wr_cnt;
    logic [15:0] cap_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_run  <= '0;
            wr_cnt  <= '0;
            cap_len <= '0;
        end else begin
            pe_run <= arr_pe ? pe_run + 32'd1 : 32'd0;
            if (arr_pe) wr_cnt <= '0;
            else if (arr_we) wr_cnt <= wr_cnt + 32'd1;
            if (start && !busy && !done) cap_len <= pulse_len;
        end
    end

    assert_refuse_misaligned_R2: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !done && (start_addr[IDX_W-1:0] != '0) |=> done && err);

    assert_xfer_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        arr_we && $past(arr_we) |-> arr_addr[IDX_W-1:0] == $past(arr_addr[IDX_W-1:0]) + IDX_W'(1));

    assert_latch_full_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(arr_pe) |-> wr_cnt == 32'(PAGE_BYTES));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(arr_pe) && !done |-> pe_run == {16'b0, cap_len});

    assert_wdt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        arr_pe |-> pe_run < 32'(WDT_CYC));

    assert_wdt_flag_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(arr_pe) && done |-> wdt_fail);

    assert_dummy_first_R8: assert property (@(posedge clk) disable iff (rst)
        arr_rd |-> $past(arr_dw) && ($past(arr_addr) == arr_addr) &&
                   ($past(arr_wdata) == ERASED) && (arr_addr[1:0] == 2'b00));

    assert_busy_hold_R12: assert property (@(posedge clk) disable iff (rst)
        busy |=> busy || done);

    assert_done_single_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_result_excl_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass, err, wdt_fail}));
endmodule

bind fpv_seq fpv_chk #(.ADDR_W(ADDR_W), .WDT_CYC(WDT_CYC)) u_chk (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .pulse_len(pulse_len),
    .busy(busy), .done(done), .pass(pass), .err(err), .wdt_fail(wdt_fail),
    .arr_we(arr_we), .arr_pe(arr_pe), .arr_dw(arr_dw), .arr_rd(arr_rd),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
);

// File: tb/tb_fpv_seq.sv
`timescale 1ns/1ps
module tb_fpv_seq;
    localparam int AW   = 10;
    localparam int WDT  = 40;
    localparam int MAXP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [6:0]    ld_idx = '0;
    logic [7:0]    ld_data = '0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [15:0]   pulse_len = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [AW-1:0] tst_addr = '0;
    logic [7:0]    tst_mask = '0;
    logic [3:0]    tst_need = '0;
    logic          busy, done, pass, err, wdt_fail;

    int n_chk  = 0;
    int n_fail = 0;
    bit over   = 0;

    always #2.5 clk = ~clk;

    fpv_seq #(.ADDR_W(AW), .WDT_CYC(WDT), .MAX_PULSES(MAXP)) dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .start(start), .start_addr(start_addr), .pulse_len(pulse_len),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tst_addr(tst_addr), .tst_mask(tst_mask), .tst_need(tst_need),
        .busy(busy), .done(done), .pass(pass), .err(err), .wdt_fail(wdt_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        if (seed < 0) return 8'h00;
        return 8'((i * 29 + seed * 13) ^ (i >> 2));
    endfunction

    task automatic load(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 7'(i); ld_data = pat(i, seed);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // compare a page: first n bytes pattern, rest 0xFF, optional special byte
    task automatic page_chk(input int base, input int n, input int seed,
                            input int sp, input logic [7:0] spv, input string req);
        int bad = 0; int fa = 0; int fe = 0;
        for (int i = 0; i < 128; i++) begin
            logic [7:0] e;
            e = (i < n) ? pat(i, seed) : 8'hFF;
            if (i == sp) e = spv;
            rd_addr = AW'(base + i);
            #0.1;
            if (rd_data !== e) begin
                if (bad == 0) begin fa = int'(rd_data); fe = int'(e); end
                bad++;
            end
        end
        chk(bad == 0, req, fa, fe);
    endtask

    task automatic run(input int a, input int L, input int poke, output int bcyc);
        @(negedge clk);
        start_addr = AW'(a); pulse_len = 16'(L); start = 1'b1;
        @(negedge clk);
        start = 1'b0; bcyc = 0;
        while (!done) begin
            if (busy) bcyc++;
            if (bcyc == poke) begin start = 1'b1; start_addr = AW'(32'h200); end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            over = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, pass, err, wdt_fail} == 5'b0, "R1 flags", int'({busy, done, pass, err, wdt_fail}), 0);
        for (int p = 0; p < 8; p++) page_chk(p * 128, 0, 0, -1, 8'h00, "R1 erased array");

        // R2 sweep of every misaligned low byte on page 4
        for (int v = 1; v < 256; v++) begin
            if (v == 8'h80) continue;
            run(32'h200 | v, 5, -1, b);
            chk(b == 0 && err && !pass && !wdt_fail, "R2 misaligned refused", b, 0);
        end
        page_chk(32'h200, 0, 0, -1, 8'h00, "R2 array untouched");

        // R4 R8 R9 R11 full page at 0x000, one pulse
        load(128, 3);
        run(32'h000, 5, -1, b);
        chk(pass && !err && !wdt_fail, "R9 single pass", int'({pass, err, wdt_fail}), 4);
        chk(b == 192 + 5, "R8 R9 busy cycles one pulse", b, 197);
        @(negedge clk);
        chk(!done, "R13 done one cycle", int'(done), 0);
        chk(pass, "R13 result held", int'(pass), 1);
        page_chk(32'h000, 128, 3, -1, 8'h00, "R11 page contents");

        // R4 partial load at 0x080 padded with 0xFF
        load(50, 7);
        run(32'h080, 7, -1, b);
        chk(pass && b == 199, "R4 partial page pass", b, 199);
        page_chk(32'h080, 50, 7, -1, 8'h00, "R4 padding");

        // R4 buffer back to all ones after done: nothing loaded, page stays erased
        run(32'h100, 3, -1, b);
        chk(pass && b == 195, "R4 empty buffer", b, 195);
        page_chk(32'h100, 0, 0, -1, 8'h00, "R4 buffer cleared");

        // R3 refuse a non-erased page and a zero pulse length
        load(128, 9);
        run(32'h000, 5, -1, b);
        chk(err && b == 0, "R3 programmed page refused", b, 0);
        page_chk(32'h000, 128, 3, -1, 8'h00, "R3 page unchanged");
        run(32'h380, 0, -1, b);
        chk(err && b == 0, "R3 zero pulse refused", b, 0);
        page_chk(32'h380, 0, 0, -1, 8'h00, "R3 zero pulse untouched");

        // R9 weak bits need three pulses
        tst_addr = AW'(32'h185); tst_mask = 8'h0F; tst_need = 4'd3;
        load(128, -1);
        run(32'h180, 4, -1, b);
        chk(pass, "R9 retry converges", int'(pass), 1);
        chk(b == 3 * 196, "R9 three pulses", b, 3 * 196);
        page_chk(32'h180, 128, -1, -1, 8'h00, "R9 page all zero");

        // R10 dead bits exhaust the pulse budget
        tst_addr = AW'(32'h28A); tst_mask = 8'h81; tst_need = 4'd15;
        load(128, -1);
        run(32'h280, 3, -1, b);
        chk({pass, err, wdt_fail} == 3'b000, "R10 fail flags", int'({pass, err, wdt_fail}), 0);
        chk(b == MAXP * 195, "R10 pulse budget", b, MAXP * 195);
        page_chk(32'h280, 128, -1, 32'h0A, 8'h81, "R10 R11 partial program kept");
        tst_need = 4'd0;

        // R7 pulse longer than watchdog window is cut
        load(128, 5);
        run(32'h300, WDT + 1, -1, b);
        chk(wdt_fail && !pass && !err, "R7 watchdog abort flags", int'({pass, err, wdt_fail}), 1);
        chk(b == 128 + WDT, "R7 watchdog cut time", b, 128 + WDT);

        // R7 pulse equal to the window ends normally; R12 start mid-run ignored
        load(128, 11);
        run(32'h380, WDT, 60, b);
        chk(pass && !wdt_fail && !err, "R7 equal length completes", int'({pass, err, wdt_fail}), 4);
        chk(b == 192 + WDT, "R12 busy unaffected by start", b, 192 + WDT);
        page_chk(32'h380, 128, 11, -1, 8'h00, "R7 page contents");
        page_chk(32'h200, 0, 0, -1, 8'h00, "R12 ignored start left page");

        if (!over) begin
            over = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule